// File: doc/BRIEF.md
# Four-Slot Edge Timestamp Capture

This block timestamps edges on one asynchronous input against a free-running counter. Four capture slots are filled in turn by a rotating event pointer. Each slot chooses its own edge, rising or falling, so one pass of the pointer can measure high time, low time and period without software help. Each slot can also zero the counter right after its capture. The next slot then holds a delta rather than an absolute time.

A small register port reads the four slots and the control word and writes them. While a debug halt is asserted, the counter obeys one of three policies: freeze at once, run on until it reads zero and then park, or ignore the halt. In the alternate waveform mode, slot 1 holds the period. The counter wraps to zero after reaching it. Slot 4 is a staging copy of slot 2, and its value moves into slot 2 only at that wrap.

Top module: `ts_capture4`

## Requirements
- R1: While rst_n is low, the counter, the event pointer, the four slots and the control word are all zero.
- R2: When no halt policy applies, no clear is due and waveform mode is off, the counter rises by exactly one per clock.
- R3: Control bits [3:0] pick the edge of slots 1..4 (bit i for slot i+1): 0 = rising, 1 = falling. An input change applied before clock edge k loads the selected slot at edge k+2 with the cnt_o value seen just before that edge.
- R4: The pointer (ptr_o, 0..3 for slots 1..4) steps 0,1,2,3,0 on each qualified edge. An edge of the other polarity neither moves the pointer nor writes any slot.
- R5: Control bits [7:4] are per-slot clear flags (bit 4+i for slot i+1). After a capture by a flagged slot, cnt_o reads zero on the following cycle.
- R6: Control bit 8 is the load enable. When it is 0, qualified edges still move the pointer (and still clear), but no slot changes.
- R7: Control bits [10:9] = 0 with dbg_halt high: the counter holds its value.
- R8: Control bits [10:9] = 1 with dbg_halt high: the counter keeps counting until it reads zero, then holds zero until dbg_halt falls.
- R9: Control bits [10:9] = 2 or 3: dbg_halt has no effect on counting.
- R10: Addresses 0..3 read and write slots 1..4 and address 4 reads and writes the 12-bit control word. Addresses 5..7 read zero.
- R11: Control bit 11 selects waveform mode. The counter goes from the slot 1 value to zero, and on that wrap slot 2 takes slot 4's value. Slot 4 writes do not reach slot 2 before the wrap. Input edges are ignored in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Asynchronous input whose edges are timestamped |
| dbg_halt | input | 1 | Debug halt request |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | CW | Register write data |
| rdata | output | CW | Register read data, combinational from addr |
| cnt_o | output | CW | Current counter value |
| ptr_o | output | 2 | Slot index the next qualified edge will load |

## Verification
The hardest state to reach is the run-to-zero halt policy. A 32-bit counter never comes back to zero in a run of practical length. The stimulus resets the block, so the counter starts low, then sets a short period and enables waveform mode. The halt is raised partway through a period, so the counter visibly runs on to the period, wraps and then parks. Random edge trains with random per-slot polarity, clear and load settings follow directed cases that cover the pointer wrap and edges of the ignored polarity.

// File: rtl/ts_cap_pkg.sv
`timescale 1ns/1ps
package ts_cap_pkg;
  localparam int NSLOT = 4;
  localparam int PW    = $clog2(NSLOT);
  localparam int AW    = $clog2(NSLOT + 1);

  localparam logic [1:0] HALT_STOP = 2'd0;
  localparam logic [1:0] HALT_ZERO = 2'd1;

  typedef struct packed {
    logic             wave_mode;
    logic [1:0]       halt_mode;
    logic             load_en;
    logic [NSLOT-1:0] clr_after;
    logic [NSLOT-1:0] edge_fall;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tsc_sync_edge.sv
`timescale 1ns/1ps
module tsc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/tsc_counter.sv
`timescale 1ns/1ps
module tsc_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic [1:0]    halt_mode,
  input  logic          clr,
  input  logic          wrap_en,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  import ts_cap_pkg::*;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run, at_period;

  always_comb begin
    unique case (halt_mode)
      HALT_STOP: run = !halt;
      HALT_ZERO: run = !halt || (cnt_q != '0);
      default:   run = 1'b1;
    endcase
  end

  assign at_period = wrap_en && (cnt_q == period);
  assign wrap      = at_period && run && !clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)            cnt_d = '0;
    else if (run) begin
      if (at_period)    cnt_d = '0;
      else              cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tsc_event_seq.sv
`timescale 1ns/1ps
module tsc_event_seq
  import ts_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rise,
  input  logic             fall,
  input  logic [NSLOT-1:0] edge_fall,
  input  logic [NSLOT-1:0] clr_after,
  output logic [PW-1:0]    ptr,
  output logic             evt,
  output logic             clr_hit
);
  logic [PW-1:0] ptr_q, ptr_d;

  assign evt     = enable && (edge_fall[ptr_q] ? fall : rise);
  assign clr_hit = evt && clr_after[ptr_q];

  always_comb begin
    ptr_d = ptr_q;
    if (evt) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/ts_capture4.sv
`timescale 1ns/1ps
module ts_capture4
  import ts_cap_pkg::*;
#(
  parameter int CW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig_in,
  input  logic          dbg_halt,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [CW-1:0] cnt_o,
  output logic [PW-1:0] ptr_o
);
  ctrl_t                     ctrl_q, ctrl_d;
  logic                      rise, fall, evt, clr_hit, shadow_xfer;
  logic [NSLOT-1:0][CW-1:0]  slot_v;

  // control word
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && addr == AW'(NSLOT)) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  tsc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sig_in), .rise(rise), .fall(fall)
  );

  tsc_event_seq u_seq (
    .clk(clk), .rst_n(rst_n), .enable(!ctrl_q.wave_mode),
    .rise(rise), .fall(fall),
    .edge_fall(ctrl_q.edge_fall), .clr_after(ctrl_q.clr_after),
    .ptr(ptr_o), .evt(evt), .clr_hit(clr_hit)
  );

  tsc_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .halt(dbg_halt), .halt_mode(ctrl_q.halt_mode),
    .clr(clr_hit), .wrap_en(ctrl_q.wave_mode), .period(slot_v[0]),
    .cnt(cnt_o), .wrap(shadow_xfer)
  );

  // capture slots: capture > shadow transfer > software write
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [CW-1:0] q, d;
    always_comb begin
      d = q;
      if (wr_en && addr == AW'(i)) d = wdata;
      if (i == 1 && shadow_xfer)   d = slot_v[NSLOT-1];
      if (evt && ctrl_q.load_en && ptr_o == PW'(i)) d = cnt_o;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign slot_v[i] = q;
  end

  always_comb begin
    rdata = '0;
    if (addr < AW'(NSLOT))       rdata = slot_v[addr[PW-1:0]];
    else if (addr == AW'(NSLOT)) rdata = CW'(ctrl_q);
  end
endmodule

// File: rtl/ts_capture4_chk.sv
`timescale 1ns/1ps
module ts_capture4_chk #(
  parameter int CW = 32,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dbg_halt,
  input logic [1:0]    halt_mode,
  input logic          wave_mode,
  input logic          evt,
  input logic          clr_hit,
  input logic [CW-1:0] cnt_o,
  input logic [PW-1:0] ptr_o
);
  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_halt && !clr_hit && !wave_mode) |=> cnt_o == CW'($past(cnt_o) + 1'b1));

  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> ptr_o == PW'($past(ptr_o) + 1'b1));

  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(ptr_o));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> cnt_o == '0);

  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && halt_mode == 2'd0 && !clr_hit) |=> $stable(cnt_o));

  a_r8_park: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && halt_mode == 2'd1 && cnt_o == '0 && !clr_hit) |=> cnt_o == '0);
endmodule

bind ts_capture4 ts_capture4_chk #(.CW(CW), .PW(ts_cap_pkg::PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt),
  .halt_mode(ctrl_q.halt_mode), .wave_mode(ctrl_q.wave_mode),
  .evt(evt), .clr_hit(clr_hit), .cnt_o(cnt_o), .ptr_o(ptr_o)
);

// File: tb/sim_ts_capture4.sv
`timescale 1ns/1ps
module sim_ts_capture4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sig_in = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, cnt_o;
  logic [1:0]  ptr_o;

  int total = 0;
  int bad = 0;
  logic [31:0] m_slot [4];
  int          m_ptr;
  logic [3:0]  m_fall, m_clr;
  logic        m_ld;

  always #2.5 clk = ~clk;

  ts_capture4 u0 (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .dbg_halt(dbg_halt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt_o(cnt_o), .ptr_o(ptr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input logic [3:0] fl, input logic [3:0] cl,
                                            input logic ld, input logic [1:0] hm, input logic wv);
    return {20'd0, wv, hm, ld, cl, fl};
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 4) m_slot[a] = d;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 3'(a);
    #1;
    d = rdata;
  endtask

  task automatic cfg(input logic [3:0] fl, input logic [3:0] cl, input logic ld,
                     input logic [1:0] hm, input logic wv);
    m_fall = fl; m_clr = cl; m_ld = ld;
    wr(4, ctrl_word(fl, cl, ld, hm, wv));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) m_slot[i] = '0;
    m_ptr = 0; m_fall = '0; m_clr = '0; m_ld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // apply one input change at a negedge and check its effect
  task automatic fire(input logic v);
    logic [31:0] expv, d;
    logic        qual;
    int          slot;
    sig_in = v;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    expv = cnt_o;
    @(posedge clk); @(negedge clk);
    slot = m_ptr;
    qual = v ? !m_fall[slot] : m_fall[slot];
    if (qual) begin
      if (m_ld) m_slot[slot] = expv;
      if (m_clr[slot]) chk("R5 counter cleared after capture", cnt_o, 32'd0);
      m_ptr = (m_ptr + 1) % 4;
    end
    chk("R4 pointer", {30'd0, ptr_o}, 32'(m_ptr));
    rd(slot, d);
    if (!qual)      chk("R4 ignored edge leaves slot", d, m_slot[slot]);
    else if (m_ld)  chk("R3 captured timestamp", d, m_slot[slot]);
    else            chk("R6 load disabled keeps slot", d, m_slot[slot]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a, d;
    int seed;
    int mx;
    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) m_slot[i] = '0;
    m_ptr = 0; m_fall = '0; m_clr = '0; m_ld = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 counter in reset", cnt_o, 32'd0);
    chk("R1 pointer in reset", {30'd0, ptr_o}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      rd(i, d);
      chk("R1 register in reset", d, 32'd0);
    end
    rst_n = 1'b1;

    // R10: register access
    wr(2, 32'hCAFE_0042);
    rd(2, d); chk("R10 slot write readback", d, 32'hCAFE_0042);
    wr(4, 32'hFFFF_F6A5);
    rd(4, d); chk("R10 control readback", d, 32'h0000_06A5);
    rd(5, d); chk("R10 unused address", d, 32'd0);
    rd(7, d); chk("R10 unused address", d, 32'd0);

    // R2: free counting
    cfg(4'b0000, 4'b0000, 1'b1, 2'd2, 1'b0);
    @(negedge clk); a = cnt_o;
    repeat (10) @(negedge clk);
    chk("R2 count by one", cnt_o, a + 32'd10);

    // R7: freeze on halt
    cfg(4'b0000, 4'b0000, 1'b1, 2'd0, 1'b0);
    a = cnt_o; dbg_halt = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 frozen in halt", cnt_o, a);
    dbg_halt = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 resumes after halt", cnt_o, a + 32'd4);

    // R9: halt ignored for policies 2 and 3
    cfg(4'b0000, 4'b0000, 1'b1, 2'd2, 1'b0);
    a = cnt_o; dbg_halt = 1'b1;
    repeat (7) @(negedge clk);
    chk("R9 policy 2 runs in halt", cnt_o, a + 32'd7);
    cfg(4'b0000, 4'b0000, 1'b1, 2'd3, 1'b0);
    a = cnt_o;
    repeat (5) @(negedge clk);
    chk("R9 policy 3 runs in halt", cnt_o, a + 32'd5);
    dbg_halt = 1'b0;

    // R3/R4 directed: mixed polarity, full pointer wrap, ignored edge
    cfg(4'b1010, 4'b0000, 1'b1, 2'd2, 1'b0);
    fire(1'b1); fire(1'b0); fire(1'b1); fire(1'b0);
    fire(1'b1);
    fire(1'b0); // slot 2 wants falling: qualified
    cfg(4'b0000, 4'b0000, 1'b1, 2'd2, 1'b0);
    fire(1'b1); fire(1'b0); // falling edge ignored at rising slot
    // R5 and R6 directed
    cfg(4'b0000, 4'b1111, 1'b1, 2'd2, 1'b0);
    fire(1'b1); fire(1'b0); fire(1'b1);
    cfg(4'b1111, 4'b0000, 1'b0, 2'd2, 1'b0);
    fire(1'b0); fire(1'b1); fire(1'b0);

    // random edge trains
    for (int it = 0; it < 80; it++) begin
      if (it % 8 == 0)
        cfg(4'($urandom), 4'($urandom), 1'($urandom_range(0, 3) != 0),
            2'($urandom_range(2, 3)), 1'b0);
      fire(~sig_in);
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      rd(i, d); chk("R3 final slot contents", d, m_slot[i]);
    end

    // R11: waveform mode from a fresh reset, counter starts low
    do_reset();
    wr(0, 32'd20);
    wr(3, 32'h0000_1234);
    cfg(4'b0000, 4'b0000, 1'b1, 2'd2, 1'b1);
    for (int k = 0; k < 100 && cnt_o != 32'd20; k++) @(negedge clk);
    @(negedge clk);
    chk("R11 wrap to zero after period", cnt_o, 32'd0);
    rd(1, d); chk("R11 shadow moved at wrap", d, 32'h0000_1234);
    mx = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
    end
    chk("R11 counter bounded by period", 32'(mx), 32'd20);
    for (int k = 0; k < 100 && cnt_o != 32'd5; k++) @(negedge clk);
    wr(3, 32'h0000_5555);
    rd(1, d); chk("R11 no transfer mid-period", d, 32'h0000_1234);
    for (int k = 0; k < 100 && cnt_o != 32'd0; k++) @(negedge clk);
    rd(1, d); chk("R11 new value after wrap", d, 32'h0000_5555);
    sig_in = ~sig_in;
    repeat (4) @(negedge clk);
    sig_in = ~sig_in;
    repeat (4) @(negedge clk);
    chk("R11 edges ignored: pointer", {30'd0, ptr_o}, 32'd0);
    rd(0, d); chk("R11 edges ignored: slot 1", d, 32'd20);

    // R8: run to zero then park
    cfg(4'b0000, 4'b0000, 1'b1, 2'd1, 1'b1);
    for (int k = 0; k < 100 && cnt_o != 32'd10; k++) @(negedge clk);
    dbg_halt = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 still counting before zero", cnt_o, 32'd15);
    repeat (25) @(negedge clk);
    chk("R8 parked at zero", cnt_o, 32'd0);
    repeat (5) @(negedge clk);
    chk("R8 stays parked", cnt_o, 32'd0);
    dbg_halt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 resumes after halt", cnt_o, 32'd3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule